// File: doc/BRIEF.md
# Current-Ramp-Limited Clock-Gating Controller

This controller sits in one power-pin domain and owns the clock enables of the small group of modules that draw current through that pin. A module asks for its clock by raising its `busy` line. When a module stays idle long enough, the controller asks on its behalf to turn its clock off. Every enable change, off-to-on or on-to-off, swings supply current by that module's weight. The controller grants changes only while the weighted sum of changes over a sliding window of recent cycles stays within a programmable threshold. This limits the current ramp the pin sees.

Requests that cannot be granted wait in a queue served in arrival order, with one slot per module. A module whose clock-on request is waiting sees its `stall` line high, so the stage that feeds it can hold. The window length, threshold, idle limit and per-module weights are static configuration inputs.

Top module: `gate_ramp_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every `clk_en` bit is 1, every `stall` bit is 0, the queue is empty, the window history is zero and all idle counters are zero.
- R2: A module with `busy` high and its clock off gets a clock-on request queued at that clock edge. If budget allows, its `clk_en` bit rises at the next edge.
- R3: `busy` high on a module whose clock is already on adds no request and consumes no budget. It also restarts that module's idle count.
- R4: A module whose clock is on and whose `busy` is low gets a clock-off request queued at the edge ending its (`cfg_idle_limit`+1)th consecutive idle cycle. Its `clk_en` bit falls one edge later if budget allows.
- R5: Both directions of change count against the budget. The weights of all enable changes granted within any `cfg_window` consecutive cycles sum to at most `cfg_threshold`. Module i's weight is `mod_weight[i*WW +: WW]`.
- R6: Queued requests are granted in arrival order. Requests arriving at the same edge are ordered by module index, lowest first. A request never overtakes an older one that is still waiting, even if the younger one would fit.
- R7: In one cycle, the longest run of oldest requests whose weights fit the remaining budget is granted. The rest stay queued for later cycles.
- R8: The window length is `cfg_window` cycles, from 1 to MAX_WIN. A length of 1 limits only the changes granted in the same cycle. A length of L also counts the grants of the previous L-1 cycles.
- R9: `stall[i]` is high exactly while a clock-on request for module i is waiting.
- R10: Each module has at most one request waiting at a time. Every grant toggles the module's enable exactly once, and the queue never holds more entries than there are modules.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_threshold | input | TW | Maximum summed weight of changes within the window |
| cfg_window | input | LW | Window length in cycles, 1 to MAX_WIN |
| cfg_idle_limit | input | DW | Idle count after which a clock-off request is raised |
| mod_weight | input | N_MOD*WW | Per-module current weights, module i at bits i*WW +: WW |
| busy | input | N_MOD | Module needs its clock this cycle |
| clk_en | output | N_MOD | Clock enable per module |
| stall | output | N_MOD | Clock-on request for that module is waiting |

## Verification
A request is queued at the edge that samples its cause. The earliest grant follows at the next edge, so a clock-on shows up on `clk_en` two edges after `busy` is first sampled. A clock-off needs `cfg_idle_limit`+2 idle-sampling edges. `stall` rises one edge after the request cause and falls together with the enable rise. Every further cycle a request waits adds exactly one edge. The expected cycle of each result is worked out by hand from these counts. The stimulus is driven on falling edges. A scoreboard item tagged with its absolute cycle number is compared at the falling edge that follows that rising edge.

// File: rtl/gate_ramp_ctrl.sv
module gate_ramp_ctrl #(
  parameter int N_MOD   = 3,
  parameter int WW      = 3,
  parameter int TW      = 4,
  parameter int MAX_WIN = 8,
  parameter int DW      = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [TW-1:0]      cfg_threshold,
  input  logic [$clog2(MAX_WIN+1)-1:0] cfg_window,
  input  logic [DW-1:0]      cfg_idle_limit,
  input  logic [N_MOD*WW-1:0] mod_weight,
  input  logic [N_MOD-1:0]   busy,
  output logic [N_MOD-1:0]   clk_en,
  output logic [N_MOD-1:0]   stall
);
  localparam int QD = N_MOD;
  localparam int IW = (N_MOD > 1) ? $clog2(N_MOD) : 1;
  localparam int CW = $clog2(QD + 1);
  localparam int SW = WW + $clog2(N_MOD * MAX_WIN + 1) + 1;

  logic [N_MOD-1:0] en_q, pend_q;
  logic [DW-1:0]    idle_cnt [N_MOD];
  logic [IW-1:0]    q_mod [QD];
  logic             q_on  [QD];
  logic [CW-1:0]    q_cnt;
  logic [SW-1:0]    hist  [MAX_WIN];

  function automatic logic [SW-1:0] wt(input logic [IW-1:0] m);
    return SW'(mod_weight[m*WW +: WW]);
  endfunction

  // budget already spent by the previous cfg_window-1 cycles
  logic [SW-1:0] used;
  always_comb begin
    used = '0;
    for (int k = 0; k < MAX_WIN - 1; k++)
      if (k + 1 < int'(cfg_window)) used = used + hist[k];
  end

  // in-order grant of the oldest run that fits
  logic [SW-1:0]    acc;
  logic [N_MOD-1:0] gmask;
  int               ngrant;
  always_comb begin
    logic blocked;
    acc = used;
    gmask = '0;
    ngrant = 0;
    blocked = 1'b0;
    for (int k = 0; k < QD; k++) begin
      if (k < int'(q_cnt) && !blocked) begin
        if (acc + wt(q_mod[k]) <= SW'(cfg_threshold)) begin
          acc = acc + wt(q_mod[k]);
          gmask[q_mod[k]] = 1'b1;
          ngrant = ngrant + 1;
        end else begin
          blocked = 1'b1;
        end
      end
    end
  end

  logic [N_MOD-1:0] want_on, want_off, new_req;
  for (genvar i = 0; i < N_MOD; i++) begin : g_req
    assign want_on[i]  = busy[i] & ~en_q[i] & ~pend_q[i];
    assign want_off[i] = ~busy[i] & en_q[i] & ~pend_q[i] &
                         (idle_cnt[i] == cfg_idle_limit);
  end
  assign new_req = want_on | want_off;

  // queue compaction: drop granted prefix, append arrivals by index
  logic [IW-1:0] nq_mod [QD];
  logic          nq_on  [QD];
  int            ncnt;
  always_comb begin
    for (int k = 0; k < QD; k++) begin
      nq_mod[k] = '0;
      nq_on[k]  = 1'b0;
      if (k + ngrant < int'(q_cnt)) begin
        nq_mod[k] = q_mod[k + ngrant];
        nq_on[k]  = q_on[k + ngrant];
      end
    end
    ncnt = int'(q_cnt) - ngrant;
    for (int i = 0; i < N_MOD; i++) begin
      if (new_req[i] && ncnt < QD) begin
        nq_mod[ncnt] = IW'(i);
        nq_on[ncnt]  = want_on[i];
        ncnt = ncnt + 1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '1;
      pend_q <= '0;
      q_cnt  <= '0;
      for (int k = 0; k < QD; k++) begin
        q_mod[k] <= '0;
        q_on[k]  <= 1'b0;
      end
      for (int k = 0; k < MAX_WIN; k++) hist[k] <= '0;
      for (int i = 0; i < N_MOD; i++) idle_cnt[i] <= '0;
    end else begin
      en_q   <= en_q ^ gmask;
      pend_q <= (pend_q & ~gmask) | new_req;
      q_cnt  <= CW'(ncnt);
      for (int k = 0; k < QD; k++) begin
        q_mod[k] <= nq_mod[k];
        q_on[k]  <= nq_on[k];
      end
      hist[0] <= acc - used;
      for (int k = 1; k < MAX_WIN; k++) hist[k] <= hist[k-1];
      for (int i = 0; i < N_MOD; i++) begin
        if (busy[i] || !en_q[i] || gmask[i])
          idle_cnt[i] <= '0;
        else if (!pend_q[i] && idle_cnt[i] != cfg_idle_limit)
          idle_cnt[i] <= idle_cnt[i] + 1'b1;
      end
    end
  end

  assign clk_en = en_q;
  assign stall  = pend_q & ~en_q;

  function automatic logic [SW-1:0] flip_weight(input logic [N_MOD-1:0] m);
    logic [SW-1:0] s;
    s = '0;
    for (int i = 0; i < N_MOD; i++) if (m[i]) s = s + wt(IW'(i));
    return s;
  endfunction

  assert_swing_budget_R5: assert property (@(posedge clk) disable iff (!rst_n)
    flip_weight($past(clk_en) ^ clk_en) <= SW'($past(cfg_threshold)));

  assert_queue_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    int'(q_cnt) <= QD);

  assert_pending_matches_queue_R10: assert property (@(posedge clk) disable iff (!rst_n)
    int'(q_cnt) == $countones(pend_q));

  for (genvar i = 0; i < N_MOD; i++) begin : g_chk
    assert_on_after_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(clk_en[i]) |-> $past(stall[i]));
    assert_stall_clears_on_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(stall[i]) |-> clk_en[i]);
  end
endmodule

// File: tb/sim_gate_ramp_ctrl.sv
module sim_gate_ramp_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] cfg_threshold = 4'd3;
  logic [3:0] cfg_window = 4'd1;
  logic [3:0] cfg_idle_limit = 4'd2;
  logic [8:0] mod_weight = {3'd2, 3'd1, 3'd2};
  logic [2:0] busy = 3'b111;
  logic [2:0] clk_en, stall;

  gate_ramp_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cfg_threshold(cfg_threshold),
    .cfg_window(cfg_window), .cfg_idle_limit(cfg_idle_limit),
    .mod_weight(mod_weight), .busy(busy), .clk_en(clk_en), .stall(stall)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int       cyc;
    logic [2:0] en;
    logic [2:0] st;
    string    tag;
  } item_t;

  item_t sb[$];
  int cyc = 0;
  int checks = 0;
  int errors = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic expect_at(input int dly, input logic [2:0] en,
                           input logic [2:0] st, input string tag);
    item_t it;
    it.cyc = cyc + dly;
    it.en  = en;
    it.st  = st;
    it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].cyc <= cyc) begin
      checks++;
      if (sb[0].cyc != cyc || clk_en !== sb[0].en || stall !== sb[0].st) begin
        errors++;
        $display("FAIL %s cyc=%0d: clk_en=%b stall=%b, expected clk_en=%b stall=%b",
                 sb[0].tag, cyc, clk_en, stall, sb[0].en, sb[0].st);
      end
      void'(sb.pop_front());
    end
    if (cyc > 5000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung, actual cyc=%0d expected below 5000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    expect_at(1, 3'b111, 3'b000, "R1");
    wait_n(2);

    // R4 decay to off, R7 partial grant at window 1
    busy = 3'b000;
    expect_at(3, 3'b111, 3'b000, "R4");
    expect_at(4, 3'b100, 3'b000, "R7");
    expect_at(5, 3'b000, 3'b000, "R7");
    wait_n(6);

    // window 2: R9 stall, R2 grant, R6 no overtaking, R8 window span
    cfg_window = 4'd2;
    busy = 3'b001;
    expect_at(1, 3'b000, 3'b001, "R9");
    wait_n(1);
    busy = 3'b101;
    expect_at(1, 3'b001, 3'b100, "R2");
    wait_n(1);
    busy = 3'b111;
    expect_at(1, 3'b001, 3'b110, "R6");
    expect_at(2, 3'b111, 3'b000, "R8");
    wait_n(3);

    // R3 activity restarts the idle count
    busy = 3'b101;
    expect_at(3, 3'b111, 3'b000, "R3");
    expect_at(6, 3'b111, 3'b000, "R3");
    expect_at(7, 3'b101, 3'b000, "R4");
    wait_n(2);
    busy = 3'b111;
    wait_n(1);
    busy = 3'b101;
    wait_n(5);

    // R5 off transitions spend budget across the window
    busy = 3'b010;
    expect_at(1, 3'b101, 3'b010, "R9");
    expect_at(2, 3'b111, 3'b000, "R2");
    expect_at(4, 3'b110, 3'b000, "R5");
    expect_at(5, 3'b110, 3'b000, "R5");
    expect_at(6, 3'b010, 3'b000, "R5");
    wait_n(7);

    // R5 larger threshold admits both; R10 single toggle per request
    cfg_threshold = 4'd5;
    cfg_window = 4'd1;
    busy = 3'b111;
    expect_at(1, 3'b010, 3'b101, "R9");
    expect_at(2, 3'b111, 3'b000, "R5");
    expect_at(3, 3'b111, 3'b000, "R10");
    wait_n(5);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule